// File: doc/BRIEF.md
# Board System Control Port Bank

This block sits on a byte-wide I/O bus and answers a small group of board-control ports. It keeps a few control bits (soft reset, byte-order flag, activity lamp, a four-bit system-control nibble and a contiguous I/O map selector) and drives them straight out to the board. It also returns fixed identification and status bytes from a set of read-only ports.

Writes to two of the ports store nothing. Each one sends a single-clock toggle pulse on one of two lock channels to an external non-volatile store. Reads are registered and appear on the read bus one clock after the read strobe. Any port that has no defined read value returns all ones.

An access outside the decoded range raises a one-clock error strobe. This strobe lets a test environment notice stray traffic.

Top module: `sysctl_port_bank`

## Requirements
- R1: The decoded range is port 0x0092 and the window 0x0800 through 0x0851. A read or write anywhere else pulses `bad_access` high for exactly the clock after the strobe. An access inside the range leaves it low.
- R2: A write to 0x0092 copies data bit 0 to the `soft_rst` level and data bit 1 to `le_mode`. A read of 0x0092 returns `le_mode` in bit 1 and zero in every other bit.
- R3: Ports 0x0800, 0x0802 and 0x0803 read as 0xEF, 0xAD and 0xE0. Writing them changes nothing.
- R4: Fixed read values: 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00, and 0x0823 gives 0x03.
- R5: A write to 0x0808 sets `led_on` from data bit 0.
- R6: A write to 0x0810 raises `lock_pulse[0]` and a write to 0x0812 raises `lock_pulse[1]`, each high for exactly one clock. The data byte is ignored and no stored state changes.
- R7: A write to 0x081C keeps only data bits 3:0 as the system-control nibble. A read returns that nibble with bits 7:4 zero.
- R8: A write to 0x0850 sets `contig_map` from data bit 0. A read returns it in bit 0, with the other bits zero.
- R9: A read of any port without a defined value returns 0xFF. This covers 0x0808, 0x0812, 0x0814, unused window ports and ports outside the range. A write to such a port is ignored.
- R10: Reset clears `soft_rst`, `le_mode`, `led_on`, `contig_map`, the system-control nibble and both lock pulses.
- R11: `rdata` updates on the clock edge that samples `io_rd` and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe, one clock per access |
| io_wr | input | 1 | Write strobe, one clock per access |
| io_wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| soft_rst | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian byte-order flag |
| led_on | output | 1 | Activity lamp state |
| contig_map | output | 1 | Contiguous I/O map mode |
| lock_pulse | output | 2 | Lock-toggle pulses, bit 0 = channel 1, bit 1 = channel 2 |
| bad_access | output | 1 | One-clock strobe for an access outside the decoded range |

## Verification
Several behaviours are checked against the port strobes on every cycle:
- `soft_rst` following bit 0 of the last write to 0x0092.
- Lock pulses appearing only after a write to their own port, and never together.
- The error strobe appearing only after an out-of-range access.
- The all-ones reply for out-of-range reads.
- The zero upper nibble of system-control reads.

The bench scenarios cover the rest:
- The full table of fixed bytes.
- Writes to read-only and undefined ports leaving stored state untouched.
- The values after reset.
- Read data holding between reads.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int IO_AW    = 16;
  localparam int IO_DW    = 8;
  localparam int SYSC_W   = 4;
  localparam int NUM_LOCK = 2;

  localparam logic [IO_AW-1:0] WIN_LO = 16'h0800;
  localparam logic [IO_AW-1:0] WIN_HI = 16'h0851;

  typedef enum logic [3:0] {
    PK_NONE, PK_HOLE, PK_CTRL, PK_ID0, PK_ID2, PK_ID3, PK_LED, PK_EQUIP,
    PK_LOCK1, PK_LOCK2, PK_KEY, PK_SYSC, PK_L2, PK_MAP
  } port_kind_e;

  function automatic port_kind_e classify(input logic [IO_AW-1:0] a);
    case (a)
      16'h0092: return PK_CTRL;
      16'h0800: return PK_ID0;
      16'h0802: return PK_ID2;
      16'h0803: return PK_ID3;
      16'h0808: return PK_LED;
      16'h080C: return PK_EQUIP;
      16'h0810: return PK_LOCK1;
      16'h0812: return PK_LOCK2;
      16'h0818: return PK_KEY;
      16'h081C: return PK_SYSC;
      16'h0823: return PK_L2;
      16'h0850: return PK_MAP;
      default:  return (a >= WIN_LO && a <= WIN_HI) ? PK_HOLE : PK_NONE;
    endcase
  endfunction

  // Hard-wired bytes; all ones where a port holds no fixed value.
  function automatic logic [IO_DW-1:0] fixed_byte(input port_kind_e k);
    case (k)
      PK_ID0:   return 8'hEF;
      PK_ID2:   return 8'hAD;
      PK_ID3:   return 8'hE0;
      PK_EQUIP: return 8'h3C;
      PK_LOCK1: return 8'h39;
      PK_KEY:   return 8'h00;
      PK_L2:    return 8'h03;
      default:  return '1;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [IO_AW-1:0]  addr,
  input  logic              rd,
  input  logic              wr,
  output port_kind_e        kind,
  output logic              wr_ctrl,
  output logic              wr_led,
  output logic              wr_sysc,
  output logic              wr_map,
  output logic [NUM_LOCK-1:0] wr_lock,
  output logic              acc_bad
);
  always_comb begin
    kind       = classify(addr);
    wr_ctrl    = wr && (kind == PK_CTRL);
    wr_led     = wr && (kind == PK_LED);
    wr_sysc    = wr && (kind == PK_SYSC);
    wr_map     = wr && (kind == PK_MAP);
    wr_lock[0] = wr && (kind == PK_LOCK1);
    wr_lock[1] = wr && (kind == PK_LOCK2);
    acc_bad    = (rd || wr) && (kind == PK_NONE);
  end
endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
  import sysctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IO_DW-1:0]    wdata,
  input  logic                wr_ctrl,
  input  logic                wr_led,
  input  logic                wr_sysc,
  input  logic                wr_map,
  input  logic [NUM_LOCK-1:0] wr_lock,
  output logic                soft_rst,
  output logic                le_mode,
  output logic                led_on,
  output logic                contig_map,
  output logic [SYSC_W-1:0]   sysc,
  output logic [NUM_LOCK-1:0] lock_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_rst   <= 1'b0;
      le_mode    <= 1'b0;
      led_on     <= 1'b0;
      contig_map <= 1'b0;
      sysc       <= '0;
    end else begin
      if (wr_ctrl) begin
        soft_rst <= wdata[0];
        le_mode  <= wdata[1];
      end
      if (wr_led)  led_on     <= wdata[0];
      if (wr_sysc) sysc       <= wdata[SYSC_W-1:0];
      if (wr_map)  contig_map <= wdata[0];
    end
  end

  // One pulse register per lock channel.
  for (genvar ch = 0; ch < NUM_LOCK; ch++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n) lock_pulse[ch] <= 1'b0;
      else        lock_pulse[ch] <= wr_lock[ch];
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  port_kind_e        kind,
  input  logic              acc_bad,
  input  logic              le_mode,
  input  logic              contig_map,
  input  logic [SYSC_W-1:0] sysc,
  output logic [IO_DW-1:0]  rdata,
  output logic              bad_access
);
  logic [IO_DW-1:0] rd_next;

  always_comb begin
    case (kind)
      PK_CTRL: rd_next = {{(IO_DW-2){1'b0}}, le_mode, 1'b0};
      PK_SYSC: rd_next = {{(IO_DW-SYSC_W){1'b0}}, sysc};
      PK_MAP:  rd_next = {{(IO_DW-1){1'b0}}, contig_map};
      default: rd_next = fixed_byte(kind);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata      <= '0;
      bad_access <= 1'b0;
    end else begin
      if (rd) rdata <= rd_next;
      bad_access <= acc_bad;
    end
  end
endmodule

// File: rtl/sysctl_port_bank.sv
module sysctl_port_bank
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  rdata,
  output logic        soft_rst,
  output logic        le_mode,
  output logic        led_on,
  output logic        contig_map,
  output logic [1:0]  lock_pulse,
  output logic        bad_access
);
  port_kind_e          kind;
  logic                wr_ctrl, wr_led, wr_sysc, wr_map, acc_bad;
  logic [NUM_LOCK-1:0] wr_lock;
  logic [SYSC_W-1:0]   sysc;

  sysctl_decode u_dec (
    .addr(io_addr), .rd(io_rd), .wr(io_wr), .kind(kind),
    .wr_ctrl(wr_ctrl), .wr_led(wr_led), .wr_sysc(wr_sysc), .wr_map(wr_map),
    .wr_lock(wr_lock), .acc_bad(acc_bad)
  );

  sysctl_state u_st (
    .clk(clk), .rst_n(rst_n), .wdata(io_wdata),
    .wr_ctrl(wr_ctrl), .wr_led(wr_led), .wr_sysc(wr_sysc), .wr_map(wr_map),
    .wr_lock(wr_lock), .soft_rst(soft_rst), .le_mode(le_mode),
    .led_on(led_on), .contig_map(contig_map), .sysc(sysc),
    .lock_pulse(lock_pulse)
  );

  sysctl_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd(io_rd), .kind(kind), .acc_bad(acc_bad),
    .le_mode(le_mode), .contig_map(contig_map), .sysc(sysc),
    .rdata(rdata), .bad_access(bad_access)
  );
endmodule

// File: rtl/sysctl_port_bank_chk.sv
module sysctl_port_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  rdata,
  input logic        soft_rst,
  input logic [1:0]  lock_pulse,
  input logic        bad_access
);
  logic outside;
  assign outside = (io_addr != 16'h0092) &&
                   ((io_addr < 16'h0800) || (io_addr > 16'h0851));

  a_r1_err_after_stray: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past((io_rd || io_wr) && outside));

  a_r2_softrst_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h0092) |=> (soft_rst == $past(io_wdata[0])));

  a_r6_lock1_source: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse[0] |-> $past(io_wr && io_addr == 16'h0810));

  a_r6_lock2_source: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse[1] |-> $past(io_wr && io_addr == 16'h0812));

  a_r6_lock_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_pulse));

  a_r7_sysc_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 16'h081C) |=> (rdata[7:4] == 4'h0));

  a_r9_stray_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && outside) |=> (rdata == 8'hFF));
endmodule

bind sysctl_port_bank sysctl_port_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .rdata(rdata), .soft_rst(soft_rst),
  .lock_pulse(lock_pulse), .bad_access(bad_access)
);

// File: tb/sysctl_port_bank_bench.sv
module sysctl_port_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] rdata;
  logic soft_rst, le_mode, led_on, contig_map, bad_access;
  logic [1:0] lock_pulse;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [15:0] a; logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t sb[$];
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_port_bank u_sysctl_port_bank (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .rdata(rdata),
    .soft_rst(soft_rst), .le_mode(le_mode), .led_on(led_on),
    .contig_map(contig_map), .lock_pulse(lock_pulse),
    .bad_access(bad_access)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare read data one clock after each sampled read strobe.
  always @(posedge clk) rd_seen <= io_rd;
  always @(negedge clk) begin
    if (rd_seen && sb.size() > 0) begin
      rd_item_t it;
      it = sb.pop_front();
      chk(rdata == it.exp, it.tag, rdata, it.exp);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.a = a; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk({soft_rst, le_mode, led_on, contig_map, lock_pulse} == 6'b0, "R10 outputs", {soft_rst, le_mode, led_on, contig_map, lock_pulse}, 0);
    rd(16'h0092, 8'h00, "R10 ctrl read");
    rd(16'h081C, 8'h00, "R10 sysc read");
    rd(16'h0850, 8'h00, "R10 map read");

    // R3 / R4 fixed bytes
    rd(16'h0800, 8'hEF, "R3 id0");
    rd(16'h0802, 8'hAD, "R3 id2");
    rd(16'h0803, 8'hE0, "R3 id3");
    rd(16'h080C, 8'h3C, "R4 equip");
    rd(16'h0810, 8'h39, "R4 extfeat");
    rd(16'h0818, 8'h00, "R4 key");
    rd(16'h0823, 8'h03, "R4 l2");
    wr(16'h0800, 8'h00);
    wr(16'h0803, 8'h55);
    rd(16'h0800, 8'hEF, "R3 id0 after write");
    rd(16'h0803, 8'hE0, "R3 id3 after write");

    // R2 control port
    wr(16'h0092, 8'h03);
    chk(soft_rst && le_mode, "R2 set both", {soft_rst, le_mode}, 3);
    chk(!bad_access, "R1 no err in range", bad_access, 0);
    rd(16'h0092, 8'h02, "R2 read le");
    wr(16'h0092, 8'hFD);
    chk(soft_rst && !le_mode, "R2 rst only", {soft_rst, le_mode}, 2);
    rd(16'h0092, 8'h00, "R2 read le clear");
    wr(16'h0092, 8'h02);
    chk(!soft_rst && le_mode, "R2 le only", {soft_rst, le_mode}, 1);

    // R5 LED
    wr(16'h0808, 8'hFF);
    chk(led_on, "R5 led on", led_on, 1);
    wr(16'h0808, 8'hFE);
    chk(!led_on, "R5 led off", led_on, 0);
    wr(16'h0808, 8'h01);

    // R7 system control nibble
    wr(16'h081C, 8'hA5);
    rd(16'h081C, 8'h05, "R7 low nibble");
    wr(16'h081C, 8'hFF);
    rd(16'h081C, 8'h0F, "R7 all ones");

    // R8 map mode
    wr(16'h0850, 8'hFF);
    chk(contig_map, "R8 map out", contig_map, 1);
    rd(16'h0850, 8'h01, "R8 map read");
    wr(16'h0850, 8'h00);
    chk(!contig_map, "R8 map clear", contig_map, 0);
    wr(16'h0850, 8'h01);

    // R6 lock pulses
    wr(16'h0810, 8'hFF);
    chk(lock_pulse == 2'b01, "R6 lock1 high", lock_pulse, 1);
    @(negedge clk);
    chk(lock_pulse == 2'b00, "R6 lock1 one clock", lock_pulse, 0);
    wr(16'h0812, 8'h00);
    chk(lock_pulse == 2'b10, "R6 lock2 high", lock_pulse, 2);
    @(negedge clk);
    chk(lock_pulse == 2'b00, "R6 lock2 one clock", lock_pulse, 0);
    chk(!soft_rst && le_mode && led_on && contig_map, "R6 state untouched",
        {soft_rst, le_mode, led_on, contig_map}, 7);
    rd(16'h081C, 8'h0F, "R6 sysc untouched");

    // R9 undefined ports
    rd(16'h0814, 8'hFF, "R9 l2inv");
    rd(16'h0808, 8'hFF, "R9 led port");
    rd(16'h0812, 8'hFF, "R9 lock2 port");
    rd(16'h0840, 8'hFF, "R9 window hole");
    wr(16'h0814, 8'h00);
    wr(16'h0851, 8'h00);
    chk(!soft_rst && le_mode && led_on && contig_map, "R9 writes ignored",
        {soft_rst, le_mode, led_on, contig_map}, 7);
    rd(16'h081C, 8'h0F, "R9 sysc kept");

    // R1 out-of-range accesses
    wr(16'h0852, 8'h00);
    chk(bad_access, "R1 err on stray write", bad_access, 1);
    @(negedge clk);
    chk(!bad_access, "R1 err one clock", bad_access, 0);
    rd(16'h0093, 8'hFF, "R9 stray read ones");
    chk(bad_access, "R1 err on stray read", bad_access, 1);
    rd(16'h07FF, 8'hFF, "R9 below window");

    // R11 hold between reads
    rd(16'h0800, 8'hEF, "R11 read");
    repeat (3) @(negedge clk);
    chk(rdata == 8'hEF, "R11 hold", rdata, 8'hEF);

    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end
endmodule